// File: doc/BRIEF.md
# Boundary Scan Register with Three-Level Address Pins

This block is the data-register half of a boundary-scan path. A chain of scan cells sits between the serial test input and the serial test output whenever the sample/preload or the external-test instruction is selected. The chain is 198 cells long. There is one cell for each two-state digital pin. Each of the two three-level address-select pins takes two cells, because it can sit low, high or floating in the middle. Every cell beyond those is reserved and always captures zero.

The TAP controller is outside this block. It presents three level strobes that mark its Capture-DR, Shift-DR and Update-DR states, a select line that says one of the two scan instructions is current, and an external-test flag. On a TCK rising edge with a strobe active, the chain does one of three things:

- It captures the live pin picture.
- It shifts one place toward the test output, cell 0 first.
- It copies its output cells into the update latches.

The functional outputs reach the pads untouched unless external test is active. While it is active, each output pad follows its update latch.

The operation decode is a small enumerated selector (`OP_HOLD`, `OP_CAPTURE`, `OP_SHIFT`, `OP_UPDATE`). It takes `OP_HOLD` whenever the chain is not selected or no single strobe is active. There is no stored state machine: each TCK edge acts only on the operation decoded for that edge.

Top module: `scan_chain_tri`

## Requirements
- R1: A bit entered on `tdi` during a shift appears on `tdo` after exactly 198 shift edges; before that, `tdo` shows the cells in index order.
- R2: On a capture edge, the cells are loaded in this layout. Cells 0..7 take the driven output pad values (bit i of `out_pad` into cell i). Cells 8..13 take `pin_in[5:0]`. Address pin j takes cells 14+2j (code bit 0) and 15+2j (code bit 1). Cell 0 is on `tdo` right after capture.
- R3: Reserved cells 18..197 capture 0.
- R4: The address level codes are: low = 00, high = 01, middle = 10. The comparator pair `addr_above_hi`/`addr_above_lo` maps as follows: 1/1 → high, 0/1 → middle, 0/0 → low, 1/0 → high. Code 11 is never captured.
- R5: With `bsr_sel` low, the capture, shift and update strobes leave both the chain and the update latches unchanged.
- R6: With `extest` low, `out_pad` equals `out_func` at all times, whatever the chain does (sample/preload runs without disturbing the pins).
- R7: With `extest` high, `out_pad` equals the update latches. The latches load cells 0..7 on an update edge.
- R8: An active-low `tlr_n` clears the chain and the update latches to zero.
- R9: Shift or capture edges without an update edge do not change the update latches or `out_pad`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tlr_n | input | 1 | Test-Logic-Reset, active low, asynchronous |
| bsr_sel | input | 1 | Sample/preload or external test is the current instruction |
| extest | input | 1 | External test is the current instruction |
| capture_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_dr | input | 1 | TAP is in Update-DR |
| tdi | input | 1 | Serial test data in |
| out_func | input | 8 | Functional values for the output pins |
| pin_in | input | 6 | Sensed values of the two-state input pins |
| addr_above_hi | input | 2 | Per address pin: level above the upper threshold |
| addr_above_lo | input | 2 | Per address pin: level above the lower threshold |
| tdo | output | 1 | Serial test data out (cell 0) |
| out_pad | output | 8 | Drive values for the output pins |

## Verification
A corrupted cell shows up on `tdo` during the shift that follows the next capture. Its position in the serial stream names the cell, and the error appears within 198 edges. A wrong update latch is visible on `out_pad` in the same cycle that external test is active, and stays there until the next update edge. A fault in the operation decode shows in one of two ways. Either `tdo` moves when it should hold, or `out_pad` changes after a shift-only sequence; both show on the next edge.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_SHIFT   = 2'd2,
        OP_UPDATE  = 2'd3
    } bsr_op_e;

    localparam logic [1:0] LVL_LOW  = 2'b00;
    localparam logic [1:0] LVL_HIGH = 2'b01;
    localparam logic [1:0] LVL_MID  = 2'b10;

    // upper comparator dominates, so an inconsistent pair reads as high
    function automatic logic [1:0] encode_level(input logic above_hi, input logic above_lo);
        logic [1:0] code;
        if (above_hi)      code = LVL_HIGH;
        else if (above_lo) code = LVL_MID;
        else               code = LVL_LOW;
        return code;
    endfunction

endpackage

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
    import bsr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sel,
    input  logic    capture_dr,
    input  logic    shift_dr,
    input  logic    update_dr,
    output bsr_op_e op
);

    always_comb begin
        op = OP_HOLD;
        if (sel) begin
            unique case ({capture_dr, shift_dr, update_dr})
                3'b100:  op = OP_CAPTURE;
                3'b010:  op = OP_SHIFT;
                3'b001:  op = OP_UPDATE;
                default: op = OP_HOLD;
            endcase
        end
    end

    // the TAP is in one data-register state at a time
    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({capture_dr, shift_dr, update_dr})); // R5

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
    import bsr_pkg::*;
#(
    parameter int LEN = 198
) (
    input  logic           clk,
    input  logic           rst_n,
    input  bsr_op_e        op,
    input  logic           tdi,
    input  logic [LEN-1:0] cap_vec,
    output logic [LEN-1:0] sh_q,
    output logic           tdo
);

    logic [LEN-1:0] sh_d;

    always_comb begin
        unique case (op)
            OP_CAPTURE: sh_d = cap_vec;
            OP_SHIFT:   sh_d = {tdi, sh_q[LEN-1:1]};
            default:    sh_d = sh_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign tdo = sh_q[0];

    AST_TDO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHIFT) |=> (tdo == $past(sh_q[1]))); // R1

    AST_TAIL_FROM_TDI: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHIFT) |=> (sh_q[LEN-1] == $past(tdi))); // R1

    AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD || op == OP_UPDATE) |=> $stable(sh_q)); // R5

endmodule

// File: rtl/bsr_update.sv
module bsr_update
    import bsr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  bsr_op_e      op,
    input  logic [W-1:0] cell_bits,
    output logic [W-1:0] upd_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                upd_q <= '0;
        else if (op == OP_UPDATE)  upd_q <= cell_bits;
    end

    AST_UPD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_UPDATE) |=> $stable(upd_q)); // R9

endmodule

// File: rtl/scan_chain_tri.sv
module scan_chain_tri
    import bsr_pkg::*;
#(
    parameter int CHAIN_LEN = 198,
    parameter int N_OUT     = 8,
    parameter int N_IN      = 6,
    parameter int N_TRI     = 2
) (
    input  logic             tck,
    input  logic             tlr_n,
    input  logic             bsr_sel,
    input  logic             extest,
    input  logic             capture_dr,
    input  logic             shift_dr,
    input  logic             update_dr,
    input  logic             tdi,
    input  logic [N_OUT-1:0] out_func,
    input  logic [N_IN-1:0]  pin_in,
    input  logic [N_TRI-1:0] addr_above_hi,
    input  logic [N_TRI-1:0] addr_above_lo,
    output logic             tdo,
    output logic [N_OUT-1:0] out_pad
);

    localparam int IN_BASE  = N_OUT;
    localparam int TRI_BASE = N_OUT + N_IN;
    localparam int USED     = TRI_BASE + 2 * N_TRI;
    localparam int RSV      = CHAIN_LEN - USED;

    bsr_op_e              op;
    logic [CHAIN_LEN-1:0] cap_vec;
    logic [CHAIN_LEN-1:0] sh_q;
    logic [N_OUT-1:0]     upd_q;

    bsr_ctrl u_ctrl (
        .clk        (tck),
        .rst_n      (tlr_n),
        .sel        (bsr_sel),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .op         (op)
    );

    // capture picture: driven outputs, sensed inputs, encoded levels, zeros
    assign cap_vec[N_OUT-1:0]          = out_pad;
    assign cap_vec[TRI_BASE-1:IN_BASE] = pin_in;

    for (genvar j = 0; j < N_TRI; j++) begin : g_tri
        assign cap_vec[TRI_BASE+2*j+1 : TRI_BASE+2*j] =
            encode_level(addr_above_hi[j], addr_above_lo[j]);

        AST_TRI_NO_RSV_CODE: assert property (@(posedge tck) disable iff (!tlr_n)
            (op == OP_CAPTURE) |=> (sh_q[TRI_BASE+2*j+1 : TRI_BASE+2*j] != 2'b11)); // R4
    end

    if (RSV > 0) begin : g_rsv
        assign cap_vec[CHAIN_LEN-1:USED] = '0;

        AST_RSV_ZERO: assert property (@(posedge tck) disable iff (!tlr_n)
            (op == OP_CAPTURE) |=> (sh_q[CHAIN_LEN-1:USED] == '0)); // R3
    end

    bsr_chain #(.LEN(CHAIN_LEN)) u_chain (
        .clk     (tck),
        .rst_n   (tlr_n),
        .op      (op),
        .tdi     (tdi),
        .cap_vec (cap_vec),
        .sh_q    (sh_q),
        .tdo     (tdo)
    );

    bsr_update #(.W(N_OUT)) u_update (
        .clk       (tck),
        .rst_n     (tlr_n),
        .op        (op),
        .cell_bits (sh_q[N_OUT-1:0]),
        .upd_q     (upd_q)
    );

    always_comb begin
        if (extest) out_pad = upd_q;
        else        out_pad = out_func;
    end

    AST_EXT_AFTER_UPDATE: assert property (@(posedge tck) disable iff (!tlr_n)
        (op == OP_UPDATE) |=> (!extest || out_pad == $past(sh_q[N_OUT-1:0]))); // R7

endmodule

// File: tb/tb_scan_chain_tri.sv
module tb_scan_chain_tri;

    localparam int LEN = 198;

    logic       tck = 1'b0;
    logic       tlr_n;
    logic       bsr_sel, extest, capture_dr, shift_dr, update_dr, tdi;
    logic [7:0] out_func;
    logic [5:0] pin_in;
    logic [1:0] addr_above_hi, addr_above_lo;
    logic       tdo;
    logic [7:0] out_pad;

    int n_checks = 0;
    int n_fail   = 0;

    scan_chain_tri dut (
        .tck(tck), .tlr_n(tlr_n), .bsr_sel(bsr_sel), .extest(extest),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .out_func(out_func), .pin_in(pin_in),
        .addr_above_hi(addr_above_hi), .addr_above_lo(addr_above_lo),
        .tdo(tdo), .out_pad(out_pad)
    );

    always #10 tck = ~tck;

    // {out_func, pin_in, above_hi, above_lo, expected cells 17..0}
    localparam logic [35:0] VEC [5] = '{
        {8'hA5, 6'h2A, 2'b00, 2'b00, 18'h02AA5},
        {8'h3C, 6'h15, 2'b01, 2'b01, 18'h0553C},
        {8'hFF, 6'h3F, 2'b00, 2'b11, 18'h2BFFF},
        {8'h00, 6'h00, 2'b10, 2'b00, 18'h10000},
        {8'h81, 6'h01, 2'b11, 2'b11, 18'h14181}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive strobes at a falling edge, let one rising edge act, return at the next falling edge
    task automatic do_op(input logic c, input logic s, input logic u, input logic d);
        capture_dr = c; shift_dr = s; update_dr = u; tdi = d;
        @(negedge tck);
        capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge tck);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [17:0]    word;
        logic [LEN-1:0] full;
        logic [7:0]     pat;

        tlr_n = 1'b0; bsr_sel = 1'b0; extest = 1'b0;
        capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0; tdi = 1'b0;
        out_func = 8'hA5; pin_in = '0; addr_above_hi = '0; addr_above_lo = '0;
        repeat (2) @(negedge tck);
        check("R8 reset tdo", {31'b0, tdo}, 32'h0);
        check("R6 reset pass-through", {24'b0, out_pad}, 32'hA5);
        tlr_n = 1'b1;
        @(negedge tck);

        // vector table: sample mode capture and serial readout
        bsr_sel = 1'b1;
        for (int v = 0; v < 5; v++) begin
            out_func      = VEC[v][35:28];
            pin_in        = VEC[v][27:22];
            addr_above_hi = VEC[v][21:20];
            addr_above_lo = VEC[v][19:18];
            do_op(1'b1, 1'b0, 1'b0, 1'b0);
            for (int k = 0; k < 18; k++) begin
                word[k] = tdo;
                do_op(1'b0, 1'b1, 1'b0, 1'b0);
            end
            check($sformatf("R2/R4 capture vector %0d", v), {14'b0, word}, {14'b0, VEC[v][17:0]});
            check("R6 pins untouched in sample", {24'b0, out_pad}, {24'b0, VEC[v][35:28]});
        end

        // full length: reserved zeros and chain length
        out_func = 8'hFF; pin_in = 6'h3F; addr_above_hi = 2'b00; addr_above_lo = 2'b11;
        do_op(1'b1, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < LEN; k++) begin
            full[k] = tdo;
            do_op(1'b0, 1'b1, 1'b0, (k == 0) ? 1'b1 : 1'b0);
        end
        check("R3 reserved cells zero", {31'b0, (full[LEN-1:18] == '0)}, 32'h1);
        check("R2 used cells in long read", {14'b0, full[17:0]}, 32'h2BFFF);
        check("R1 tdi bit after 198 shifts", {31'b0, tdo}, 32'h1);

        // preload, then external test
        pat = 8'hC3;
        out_func = 8'h5A;
        for (int k = 0; k < LEN; k++) do_op(1'b0, 1'b1, 1'b0, (k < 8) ? pat[k] : 1'b0);
        do_op(1'b0, 1'b0, 1'b1, 1'b0);
        check("R6 preload keeps functional drive", {24'b0, out_pad}, 32'h5A);
        extest = 1'b1;
        #1;
        check("R7 extest drives latches", {24'b0, out_pad}, 32'hC3);
        out_func = 8'h12;
        #1;
        check("R7 functional value ignored in extest", {24'b0, out_pad}, 32'hC3);
        for (int k = 0; k < 5; k++) do_op(1'b0, 1'b1, 1'b0, 1'b1);
        check("R9 shift without update holds pads", {24'b0, out_pad}, 32'hC3);
        check("R1 tdo after 5 extra shifts", {31'b0, tdo}, 32'h0);

        bsr_sel = 1'b0;
        do_op(1'b0, 1'b0, 1'b1, 1'b0);
        check("R5 update ignored when unselected", {24'b0, out_pad}, 32'hC3);
        do_op(1'b1, 1'b0, 1'b0, 1'b0);
        check("R5 capture ignored when unselected", {31'b0, tdo}, 32'h0);
        do_op(1'b0, 1'b1, 1'b0, 1'b1);
        check("R5 shift ignored when unselected", {31'b0, tdo}, 32'h0);

        bsr_sel = 1'b1;
        do_op(1'b0, 1'b0, 1'b1, 1'b0);
        check("R7 update loads shifted cells", {24'b0, out_pad}, 32'h06);
        do_op(1'b1, 1'b0, 1'b0, 1'b0);
        check("R9 capture without update holds pads", {24'b0, out_pad}, 32'h06);
        check("R2 capture sees driven pad bit 0", {31'b0, tdo}, 32'h0);

        tlr_n = 1'b0;
        #1;
        check("R8 reset clears latches", {24'b0, out_pad}, 32'h00);
        check("R8 reset clears chain", {31'b0, tdo}, 32'h0);
        @(negedge tck);
        tlr_n = 1'b1;
        extest = 1'b0;
        #1;
        check("R6 leaving extest restores function", {24'b0, out_pad}, 32'h12);

        finish_run();
    end

endmodule